// File: doc/BRIEF.md
# Interval Timer with Chained Reload

This block is a byte-wide peripheral timer with one 16-bit down-counter, a 16-bit reload latch, an interrupt flag, an interrupt enable mask and an active-low interrupt output. A CPU reaches it through a 4-bit register select and 8-bit read and write data. The counter steps once per `tick` strobe, so the host picks the count rate by how often it pulses that input.

In continuous mode each expiry reloads the counter from the latch. Software may rewrite the latch while the counter is still running. The new value then sets the length of the period that follows. Chained periods therefore add up exactly, however late the interrupt handler runs and however long interrupts stay masked. In single mode the counter raises the flag only once per load, then keeps counting down through the wrap without reloading.

Selects that the block does not implement take writes with no effect and read as zero.

Top module: `vti_t1_unit`

## Requirements
- R1: After reset the interrupt output is high. Select 13 reads 0x00, select 14 reads 0x80, select 11 reads 0x00, and the counter and latch hold 0xFFFF, so select 4 reads 0xFF.
- R2: Select 6 writes the low latch byte and select 7 writes the high latch byte. Both read back at the same selects. Neither write changes the counter. A write to select 7 clears the expiry flag.
- R3: A write to select 5 puts the data byte into the latch high byte and loads the counter with {data, latch low byte}. It clears the expiry flag and re-arms single mode. A load in the same cycle as a tick wins, and no decrement happens. Selects 4 and 5 read the counter's low and high bytes.
- R4: The counter decrements only on a tick. The tick that finds the counter at zero is the expiry: the counter becomes 0xFFFF and the flag (select 13 bit 6) sets. After a load of N, the first expiry comes on tick N+1. In continuous mode the next tick reloads the latch value, so later expiries come every latch+2 ticks.
- R5: A latch write during a count leaves the current period unchanged and sets the length of the next one.
- R6: Writing select 13 with bit 6 = 1 clears the flag. Writing it with bit 6 = 0 leaves the flag unchanged. Reading select 4 clears the flag.
- R7: Select 14 holds the enable mask in bits 6..0. A write with bit 7 = 1 sets the bits given as 1, and a write with bit 7 = 0 clears them. Bit 7 reads as 1.
- R8: Select 13 bit 7 reads as (flag AND enable bit 6). `irq_n` is low exactly when that bit is 1.
- R9: Select 11 bit 6 selects continuous mode (1) or single mode (0). In single mode only the first expiry after a load sets the flag, and after the wrap the counter keeps counting down from 0xFFFF with no reload.
- R10: When an expiry and a flag clear (select 13 write, select 4 read) fall in the same cycle, the flag ends set.
- R11: Writes to selects 0–3, 8–10, 12 and 15 change no state, and reads of those selects return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Count enable strobe, one decrement per cycle high |
| cs | input | 1 | Register access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read (reads of select 4 have a side effect) |
| addr | input | 4 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from select |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The risky overlap is a counter expiry landing in the same clock as software clearing the flag, either by a flag-register write or by the counter-low read. The bench builds this deterministically: it loads a zero count and then issues the clear together with a tick. It then reads the flag register and expects bit 6 still set, because the new timeout must not be lost. Random traffic also makes load-versus-tick and latch-write-versus-reload coincidences. A cycle model in the bench judges every read and every interrupt level.

// File: rtl/vti_pkg.sv
package vti_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CNT_W   = 2 * BYTE_W;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned EN_W    = BYTE_W - 1;
  localparam int unsigned T1_BIT  = 6;
  localparam int unsigned ANY_BIT = BYTE_W - 1;

  localparam logic [SEL_W-1:0] SEL_CNT_LO  = 4'd4;
  localparam logic [SEL_W-1:0] SEL_CNT_HI  = 4'd5;
  localparam logic [SEL_W-1:0] SEL_LAT_LO  = 4'd6;
  localparam logic [SEL_W-1:0] SEL_LAT_HI  = 4'd7;
  localparam logic [SEL_W-1:0] SEL_MODE    = 4'd11;
  localparam logic [SEL_W-1:0] SEL_FLAGS   = 4'd13;
  localparam logic [SEL_W-1:0] SEL_ENABLES = 4'd14;

  typedef enum logic [1:0] {
    STEP_HOLD,
    STEP_DEC,
    STEP_WRAP,
    STEP_RELOAD
  } step_e;

  // Which action a tick performs on the counter.
  function automatic step_e pick_step(input logic tick_i, input logic reload_i,
                                      input logic zero_i);
    if (!tick_i)      return STEP_HOLD;
    else if (reload_i) return STEP_RELOAD;
    else if (zero_i)  return STEP_WRAP;
    else              return STEP_DEC;
  endfunction

  // Enable-mask update: top bit chooses set or clear of the given bits.
  function automatic logic [EN_W-1:0] mask_update(input logic [EN_W-1:0] old_i,
                                                  input logic [BYTE_W-1:0] wd_i);
    if (wd_i[BYTE_W-1]) return old_i | wd_i[EN_W-1:0];
    else                return old_i & ~wd_i[EN_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] flags_byte(input logic flag_i, input logic any_i);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[T1_BIT]  = flag_i;
    b[ANY_BIT] = any_i;
    return b;
  endfunction

  function automatic logic [BYTE_W-1:0] mode_byte(input logic free_i);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[T1_BIT] = free_i;
    return b;
  endfunction

endpackage

// File: rtl/vti_t1_regs.sv
module vti_t1_regs
  import vti_pkg::*;
#(
  parameter int unsigned BW = BYTE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic            wr_mode,
  input  logic [BW-1:0]   wdata,
  output logic [2*BW-1:0] latch_q,
  output logic            free_run
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q  <= '1;
      free_run <= 1'b0;
    end else begin
      if (wr_lo)   latch_q[BW-1:0]    <= wdata;
      if (wr_hi)   latch_q[2*BW-1:BW] <= wdata;
      if (wr_mode) free_run           <= wdata[T1_BIT];
    end
  end

endmodule

// File: rtl/vti_t1_count.sv
module vti_t1_count
  import vti_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load_go,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] latch_val,
  input  logic          free_run,
  output logic [CW-1:0] cnt,
  output logic          expire,
  output logic          fire,
  output logic          armed
);

  logic  reload_due;
  step_e step;

  assign step   = load_go ? STEP_HOLD : pick_step(tick, reload_due, cnt == '0);
  assign expire = (step == STEP_WRAP);
  assign fire   = expire && (free_run || armed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '1;
      reload_due <= 1'b0;
      armed      <= 1'b0;
    end else if (load_go) begin
      cnt        <= load_val;
      reload_due <= 1'b0;
      armed      <= 1'b1;
    end else begin
      unique case (step)
        STEP_RELOAD: begin
          cnt        <= latch_val;
          reload_due <= 1'b0;
        end
        STEP_WRAP: begin
          cnt        <= '1;
          reload_due <= free_run;
          if (!free_run) armed <= 1'b0;
        end
        STEP_DEC:  cnt <= cnt - 1'b1;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/vti_t1_irq.sv
module vti_t1_irq
  import vti_pkg::*;
#(
  parameter int unsigned BW = BYTE_W,
  localparam int unsigned EW = BW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_t1,
  input  logic          clr_t1,
  input  logic          wr_en,
  input  logic [BW-1:0] wdata,
  output logic          flag_t1,
  output logic [EW-1:0] ier_q,
  output logic          irq_any
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_t1 <= 1'b0;
      ier_q   <= '0;
    end else begin
      // A new timeout outranks a simultaneous clear.
      if (set_t1)      flag_t1 <= 1'b1;
      else if (clr_t1) flag_t1 <= 1'b0;
      if (wr_en) ier_q <= mask_update(ier_q, wdata);
    end
  end

  assign irq_any = flag_t1 && ier_q[T1_BIT];

endmodule

// File: rtl/vti_t1_unit.sv
module vti_t1_unit
  import vti_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cs,
  input  logic              we,
  input  logic [SEL_W-1:0]  addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq_n
);

  logic              wr, rd;
  logic              load_go, clr_t1;
  logic [CNT_W-1:0]  latch_q, load_val, cnt;
  logic              free_run, expire, fire, armed;
  logic              flag_t1, irq_any;
  logic [EN_W-1:0]   ier_q;

  assign wr       = cs && we;
  assign rd       = cs && !we;
  assign load_go  = wr && (addr == SEL_CNT_HI);
  assign load_val = {wdata, latch_q[BYTE_W-1:0]};
  assign clr_t1   = load_go
                 || (wr && (addr == SEL_LAT_HI))
                 || (wr && (addr == SEL_FLAGS) && wdata[T1_BIT])
                 || (rd && (addr == SEL_CNT_LO));

  vti_t1_regs #(.BW(BYTE_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo    (wr && (addr == SEL_LAT_LO)),
    .wr_hi    (wr && ((addr == SEL_LAT_HI) || (addr == SEL_CNT_HI))),
    .wr_mode  (wr && (addr == SEL_MODE)),
    .wdata    (wdata),
    .latch_q  (latch_q),
    .free_run (free_run)
  );

  vti_t1_count #(.CW(CNT_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load_go   (load_go),
    .load_val  (load_val),
    .latch_val (latch_q),
    .free_run  (free_run),
    .cnt       (cnt),
    .expire    (expire),
    .fire      (fire),
    .armed     (armed)
  );

  vti_t1_irq #(.BW(BYTE_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_t1  (fire),
    .clr_t1  (clr_t1),
    .wr_en   (wr && (addr == SEL_ENABLES)),
    .wdata   (wdata),
    .flag_t1 (flag_t1),
    .ier_q   (ier_q),
    .irq_any (irq_any)
  );

  always_comb begin
    unique case (addr)
      SEL_CNT_LO:  rdata = cnt[BYTE_W-1:0];
      SEL_CNT_HI:  rdata = cnt[CNT_W-1:BYTE_W];
      SEL_LAT_LO:  rdata = latch_q[BYTE_W-1:0];
      SEL_LAT_HI:  rdata = latch_q[CNT_W-1:BYTE_W];
      SEL_MODE:    rdata = mode_byte(free_run);
      SEL_FLAGS:   rdata = flags_byte(flag_t1, irq_any);
      SEL_ENABLES: rdata = {1'b1, ier_q};
      default:     rdata = '0;
    endcase
  end

  assign irq_n = !irq_any;

endmodule

// File: rtl/vti_t1_checker.sv
module vti_t1_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        cs,
  input logic        we,
  input logic [3:0]  addr,
  input logic [7:0]  rdata,
  input logic        irq_n,
  input logic        load_go,
  input logic [15:0] load_val,
  input logic [15:0] cnt,
  input logic        expire,
  input logic        fire,
  input logic        armed,
  input logic        free_run,
  input logic        clr_t1,
  input logic        flag_t1,
  input logic [6:0]  ier_q
);

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> (cnt == $past(load_val)) && !flag_t1);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_go) |=> $stable(cnt));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt == 16'hFFFF));

  assert_latch_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && (addr == 4'd6 || addr == 4'd7) && !tick) |=> $stable(cnt));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_t1 && !fire) |=> !flag_t1);

  assert_enable_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && addr == 4'd14) |-> rdata[7]);

  assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_t1 && ier_q[6]) |-> !irq_n);

  assert_single_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !free_run) |=> !armed);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> flag_t1);

endmodule

bind vti_t1_unit vti_t1_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .cs       (cs),
  .we       (we),
  .addr     (addr),
  .rdata    (rdata),
  .irq_n    (irq_n),
  .load_go  (load_go),
  .load_val (load_val),
  .cnt      (cnt),
  .expire   (expire),
  .fire     (fire),
  .armed    (armed),
  .free_run (free_run),
  .clr_t1   (clr_t1),
  .flag_t1  (flag_t1),
  .ier_q    (ier_q)
);

// File: tb/vti_t1_unit_bench.sv
module vti_t1_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, cs = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n;

  int checks = 0, fails = 0, n = 0;
  bit done = 1'b0;
  logic [7:0] last_rd;

  // Bench model state
  logic [15:0] m_cnt = 16'hFFFF, m_lat = 16'hFFFF;
  bit          m_rel = 0, m_arm = 0, m_flag = 0, m_fr = 0;
  logic [6:0]  m_ier = '0;

  always #2 clk = ~clk;

  vti_t1_unit u_vti_t1_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cs(cs), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [3:0] a);
    case (a)
      4'd4:  return m_cnt[7:0];
      4'd5:  return m_cnt[15:8];
      4'd6:  return m_lat[7:0];
      4'd7:  return m_lat[15:8];
      4'd11: return {1'b0, m_fr, 6'b0};
      4'd13: return {m_flag & m_ier[6], m_flag, 6'b0};
      4'd14: return {1'b1, m_ier};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step(input bit c, input bit w, input logic [3:0] a,
                            input logic [7:0] d, input bit t);
    logic [15:0] o_lat;
    bit o_fr, set, clr, ld;
    o_lat = m_lat; o_fr = m_fr; set = 0; clr = 0;
    ld = c && w && (a == 4'd5);
    if (c && w) begin
      case (a)
        4'd6:  m_lat[7:0] = d;
        4'd7:  begin m_lat[15:8] = d; clr = 1; end
        4'd5:  begin m_lat[15:8] = d; clr = 1; end
        4'd11: m_fr = d[6];
        4'd13: if (d[6]) clr = 1;
        4'd14: m_ier = d[7] ? (m_ier | d[6:0]) : (m_ier & ~d[6:0]);
        default: ;
      endcase
    end
    if (c && !w && a == 4'd4) clr = 1;
    if (ld) begin
      m_cnt = {d, o_lat[7:0]}; m_rel = 0; m_arm = 1;
    end else if (t) begin
      if (m_rel) begin m_cnt = o_lat; m_rel = 0; end
      else if (m_cnt == 16'h0000) begin
        m_cnt = 16'hFFFF; set = o_fr || m_arm; m_rel = o_fr;
        if (!o_fr) m_arm = 0;
      end else m_cnt = m_cnt - 16'd1;
    end
    if (set) m_flag = 1;
    else if (clr) m_flag = 0;
  endtask

  // One bus cycle: drive at the falling edge, judge before the rising edge.
  task automatic op(input bit c, input bit w, input logic [3:0] a,
                    input logic [7:0] d, input bit t, input string tag);
    @(negedge clk);
    cs = c; we = w; addr = a; wdata = d; tick = t;
    #1;
    last_rd = rdata;
    if (c && !w) chk(tag, rdata, model_read(a));
    chk("R8", {7'b0, irq_n}, {7'b0, ~(m_flag & m_ier[6])});
    model_step(c, w, a, d, t);
    @(posedge clk);
    #1;
    cs = 0; we = 0; tick = 0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    op(1, 0, a, 8'h00, 0, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
    op(1, 1, a, d, 0, tag);
  endtask

  task automatic wait_flag(output int k);
    k = 0;
    do begin op(0, 0, 0, 0, 1, "R4"); k++; end while (irq_n && k < 300);
  endtask

  // Ticks from the expiry just seen to the next, clearing on the first tick.
  task automatic measure(input int wr_at, input logic [7:0] wv, output int k);
    k = 0;
    do begin
      if (k == 0)          op(1, 1, 4'd13, 8'h40, 1, "R6");
      else if (k == wr_at) op(1, 1, 4'd6, wv, 1, "R5");
      else                 op(0, 0, 0, 0, 1, "R4");
      k++;
    end while (irq_n && k < 300);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(4'd13, "R1"); chk("R1", last_rd, 8'h00);
    rd(4'd14, "R1"); chk("R1", last_rd, 8'h80);
    rd(4'd11, "R1"); chk("R1", last_rd, 8'h00);
    rd(4'd5,  "R1"); chk("R1", last_rd, 8'hFF);
    chk("R1", {7'b0, irq_n}, 8'h01);

    // R2 latch bytes, counter untouched
    wr(4'd6, 8'h34, "R2"); wr(4'd7, 8'h12, "R2");
    rd(4'd6, "R2"); chk("R2", last_rd, 8'h34);
    rd(4'd7, "R2"); chk("R2", last_rd, 8'h12);
    rd(4'd5, "R2"); chk("R2", last_rd, 8'hFF);

    // R7 enable set, R9 continuous mode select, R3 load
    wr(4'd14, 8'hC0, "R7"); rd(4'd14, "R7"); chk("R7", last_rd, 8'hC0);
    wr(4'd11, 8'h40, "R9"); rd(4'd11, "R9"); chk("R9", last_rd, 8'h40);
    wr(4'd6, 8'h05, "R3"); wr(4'd5, 8'h00, "R3");
    rd(4'd4, "R3"); chk("R3", last_rd, 8'h05);
    rd(4'd5, "R3"); chk("R3", last_rd, 8'h00);
    op(1, 1, 4'd5, 8'h00, 1, "R3");
    rd(4'd4, "R3"); chk("R3", last_rd, 8'h05);

    // R4 first expiry after N+1 ticks, then latch+2
    wait_flag(n); chk("R4", n[7:0], 8'd6);
    rd(4'd5, "R4"); chk("R4", last_rd, 8'hFF);
    measure(-1, 8'h00, n); chk("R4", n[7:0], 8'd7);
    // R5 latch rewrite mid-count affects only the next period
    measure(2, 8'h03, n); chk("R5", n[7:0], 8'd7);
    measure(-1, 8'h00, n); chk("R5", n[7:0], 8'd5);

    // R6 clear rules
    wr(4'd13, 8'h00, "R6"); rd(4'd13, "R6"); chk("R6", last_rd, 8'hC0);
    wr(4'd13, 8'h40, "R6"); rd(4'd13, "R6"); chk("R6", last_rd, 8'h00);
    wait_flag(n); rd(4'd4, "R6"); rd(4'd13, "R6"); chk("R6", last_rd, 8'h00);
    wait_flag(n); wr(4'd7, 8'h00, "R2"); rd(4'd13, "R2"); chk("R2", last_rd, 8'h00);

    // R7 / R8 masking
    wait_flag(n); wr(4'd14, 8'h40, "R7");
    rd(4'd14, "R7"); chk("R7", last_rd, 8'h80);
    chk("R8", {7'b0, irq_n}, 8'h01);
    rd(4'd13, "R8"); chk("R8", last_rd, 8'h40);
    wr(4'd14, 8'hC0, "R7"); chk("R8", {7'b0, irq_n}, 8'h00);

    // R10 expiry coinciding with clears
    wr(4'd6, 8'h00, "R10"); wr(4'd5, 8'h00, "R10");
    op(1, 1, 4'd13, 8'h40, 1, "R10");
    rd(4'd13, "R10"); chk("R10", last_rd, 8'hC0);
    op(0, 0, 0, 0, 1, "R10");
    op(1, 0, 4'd4, 8'h00, 1, "R10"); chk("R10", last_rd, 8'h00);
    rd(4'd13, "R10"); chk("R10", last_rd, 8'hC0);

    // R9 single mode
    wr(4'd11, 8'h00, "R9"); wr(4'd6, 8'h02, "R9"); wr(4'd5, 8'h00, "R9");
    wait_flag(n); chk("R9", n[7:0], 8'd3);
    wr(4'd13, 8'h40, "R9");
    op(0, 0, 0, 0, 1, "R9");
    rd(4'd4, "R9"); chk("R9", last_rd, 8'hFE);
    rd(4'd5, "R9"); chk("R9", last_rd, 8'hFF);
    for (int i = 0; i < 65540; i++) op(0, 0, 0, 0, 1, "R9");
    rd(4'd13, "R9"); chk("R9", last_rd, 8'h00);

    // R11 unused selects
    for (int s = 0; s < 16; s++) begin
      if (s < 4 || (s > 7 && s < 11) || s == 12 || s == 15) begin
        wr(s[3:0], 8'hFF, "R11");
        rd(s[3:0], "R11"); chk("R11", last_rd, 8'h00);
      end
    end
    rd(4'd11, "R11"); rd(4'd14, "R11"); rd(4'd6, "R11"); rd(4'd7, "R11");

    // Random traffic against the model
    wr(4'd11, 8'h40, "R9");
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a;
      logic [7:0] d;
      bit w, t;
      case ($urandom % 12)
        0, 1: a = 4'd4;
        2:    a = 4'd5;
        3:    a = 4'd6;
        4:    a = 4'd7;
        5:    a = 4'd11;
        6, 7: a = 4'd13;
        8:    a = 4'd14;
        9:    a = 4'd9;
        default: a = 4'd0;
      endcase
      w = ($urandom % 3) == 0;
      d = 8'($urandom);
      if (a == 4'd5 || a == 4'd7) d = 8'($urandom % 2);
      if (a == 4'd11 && ($urandom % 4) != 0) d[6] = 1'b1;
      t = ($urandom % 4) != 0;
      op(($urandom % 3) != 0, w, a, d, t, "R4");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule